// File: doc/BRIEF.md
# Tagged Handshake Word Port

This block connects a stack-oriented processor core to several external word channels. Each channel uses a four-phase interlocked request/acknowledge handshake. Every word on a channel is one bit wider than the core's data word. The extra top bit is a tag that splits a single incoming stream into two kinds of traffic:

- A word with a cleared tag is handed to the data-stack push interface. It needs no explicit load instruction.
- A word with a set tag is handed to the instruction execute interface.

On the outgoing side, the core sends a data word to a named channel. The port appends a tag bit taken from a per-channel field of the control register.

The control register also holds a lock flag for each channel. A locked channel takes no input, but it can still send.

The core can also perform a programmed read of one named channel. The read stalls until that channel holds a word, and the word then goes to the read interface instead of being routed by its tag.

Handshake inputs from outside the clock domain pass through two-flop synchronizers. Collisions, timeouts and deadlock recovery are left to the surrounding system: a party that never answers stalls the transfer indefinitely.

Top module: `tagged_word_port`

## Requirements
- R1: An input channel raises its acknowledge only after its request has been seen high and the captured word has been taken downstream. It then holds the acknowledge while the request stays high, and drops it once the request falls.
- R2: An incoming word whose tag (bit DATA_W) is 0 appears on push_data_o with push_valid_o high, carrying the low DATA_W bits unchanged.
- R3: An incoming word whose tag (bit DATA_W) is 1 appears on exec_instr_o with exec_valid_o high, carrying the low DATA_W bits unchanged.
- R4: While control bit 2p+1 is set, channel p captures no word and never acknowledges. Its output side keeps working.
- R5: A word sent on output channel p carries control bit 2p, sampled when the send is accepted, as its tag (bit DATA_W).
- R6: An output word is driven before the output request rises and stays stable while the request is high. The request stays high until the acknowledge is seen, and a new request waits until the acknowledge has dropped.
- R7: While rd_req_i names channel p, rd_valid_o stays low until channel p holds a word. That word, tag included, is then delivered on rd_word_o and does not reach the push or execute interfaces.
- R8: When several channels hold words for the same interface, the lowest-numbered channel is served first.
- R9: While the push or execute interface is not ready, the pending word stays presented and unchanged, and the channel's acknowledge stays low.
- R10: After reset, all acknowledges, output requests and the valid signals of the push, execute and read interfaces are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 2*NUM_PORTS | Control register: bit 2p is the output tag for channel p, bit 2p+1 is the lock flag for channel p |
| in_req_i | input | NUM_PORTS | Asynchronous request from each external sender |
| in_word_i | input | NUM_PORTS x (DATA_W+1) | Tagged word from each sender |
| in_ack_o | output | NUM_PORTS | Acknowledge to each sender |
| push_valid_o | output | 1 | Data word offered to the data stack |
| push_data_o | output | DATA_W | Data word for the data stack |
| push_ready_i | input | 1 | Data stack accepts the word |
| exec_valid_o | output | 1 | Instruction word offered for execution |
| exec_instr_o | output | DATA_W | Instruction word |
| exec_ready_i | input | 1 | Execution path accepts the word |
| rd_req_i | input | 1 | Programmed read pending |
| rd_port_i | input | PW | Channel named by the programmed read |
| rd_valid_o | output | 1 | Programmed read completes this cycle |
| rd_word_o | output | DATA_W+1 | Word returned by the programmed read, tag included |
| send_valid_i | input | 1 | Core requests an output transfer |
| send_port_i | input | PW | Output channel selected for the send |
| send_data_i | input | DATA_W | Data word to send |
| send_ready_o | output | 1 | Selected output channel is idle and takes the send |
| out_req_o | output | NUM_PORTS | Request to each external receiver |
| out_word_o | output | NUM_PORTS x (DATA_W+1) | Tagged word to each receiver |
| out_ack_i | input | NUM_PORTS | Asynchronous acknowledge from each receiver |

## Verification
The following properties are checked by assertions on every cycle: the interlock of each input acknowledge, the hold of a pending word under backpressure, the inertness of a locked idle channel, the stability and hold of each output request, the single push grant, and the diversion of a named channel's word to the read interface.

The remaining behaviour is observable only through the bench's scenarios, where expected words are queued and compared as they leave. These scenarios cover:

- routing of words by tag across several channels;
- service order between competing channels;
- the output tag taken from the control register;
- the stall of a programmed read before its word arrives;
- release of a locked channel once it is unlocked.

// File: rtl/twp_pkg.sv
package twp_pkg;
  typedef enum logic [1:0] {RX_IDLE, RX_FULL, RX_ACK} rx_state_e;
  typedef enum logic [1:0] {TX_IDLE, TX_SETUP, TX_REQ, TX_REL} tx_state_e;
endpackage

// File: rtl/twp_sync2.sv
module twp_sync2 #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/twp_rx_chan.sv
module twp_rx_chan
  import twp_pkg::*;
#(
  parameter int WORD_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,     // synchronized
  input  logic [WORD_W-1:0] word_i,
  input  logic              lock_i,
  input  logic              accept_i,
  output logic              full_o,
  output logic [WORD_W-1:0] word_o,
  output logic              ack_o
);
  rx_state_e         state_q;
  logic [WORD_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= RX_IDLE;
      hold_q  <= '0;
    end else begin
      unique case (state_q)
        RX_IDLE: if (req_i && !lock_i) begin
          hold_q  <= word_i;
          state_q <= RX_FULL;
        end
        RX_FULL: if (accept_i) state_q <= RX_ACK;
        RX_ACK:  if (!req_i) state_q <= RX_IDLE;
        default: state_q <= RX_IDLE;
      endcase
    end
  end

  assign full_o = (state_q == RX_FULL);
  assign ack_o  = (state_q == RX_ACK);
  assign word_o = hold_q;

  // R1
  ack_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o && req_i |=> ack_o);
  // R1
  ack_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ack_o) |-> $past(accept_i) && $past(req_i));
  // R4
  lock_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == RX_IDLE) && lock_i |=> !full_o && !ack_o);
  // R9
  hold_pending_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && !accept_i |=> full_o && $stable(word_o) && !ack_o);
endmodule

// File: rtl/twp_tx_chan.sv
module twp_tx_chan
  import twp_pkg::*;
#(
  parameter int WORD_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              ack_i,     // synchronized
  output logic              idle_o,
  output logic              req_o,
  output logic [WORD_W-1:0] word_o
);
  tx_state_e         state_q;
  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      word_q  <= '0;
    end else begin
      unique case (state_q)
        TX_IDLE: if (start_i) begin
          word_q  <= word_i;
          state_q <= TX_SETUP;    // word leads request by one cycle
        end
        TX_SETUP: state_q <= TX_REQ;
        TX_REQ:   if (ack_i) state_q <= TX_REL;
        TX_REL:   if (!ack_i) state_q <= TX_IDLE;
        default:  state_q <= TX_IDLE;
      endcase
    end
  end

  assign idle_o = (state_q == TX_IDLE);
  assign req_o  = (state_q == TX_REQ);
  assign word_o = word_q;

  // R6
  word_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> $stable(word_o));
  // R6
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o && !ack_i |=> req_o);
endmodule

// File: rtl/tagged_word_port.sv
module tagged_word_port #(
  parameter  int DATA_W    = 16,
  parameter  int NUM_PORTS = 4,
  localparam int WORD_W    = DATA_W + 1,
  localparam int PW        = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int CTRL_W    = 2 * NUM_PORTS
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic [CTRL_W-1:0]                ctrl_i,
  input  logic [NUM_PORTS-1:0]             in_req_i,
  input  logic [NUM_PORTS-1:0][WORD_W-1:0] in_word_i,
  output logic [NUM_PORTS-1:0]             in_ack_o,
  output logic                             push_valid_o,
  output logic [DATA_W-1:0]                push_data_o,
  input  logic                             push_ready_i,
  output logic                             exec_valid_o,
  output logic [DATA_W-1:0]                exec_instr_o,
  input  logic                             exec_ready_i,
  input  logic                             rd_req_i,
  input  logic [PW-1:0]                    rd_port_i,
  output logic                             rd_valid_o,
  output logic [WORD_W-1:0]                rd_word_o,
  input  logic                             send_valid_i,
  input  logic [PW-1:0]                    send_port_i,
  input  logic [DATA_W-1:0]                send_data_i,
  output logic                             send_ready_o,
  output logic [NUM_PORTS-1:0]             out_req_o,
  output logic [NUM_PORTS-1:0][WORD_W-1:0] out_word_o,
  input  logic [NUM_PORTS-1:0]             out_ack_i
);
  logic [NUM_PORTS-1:0]             req_s, ack_s;
  logic [NUM_PORTS-1:0]             full_w, accept_w, tx_idle_w, start_w;
  logic [NUM_PORTS-1:0][WORD_W-1:0] hold_w;
  logic [NUM_PORTS-1:0]             want_push, want_exec, want_rd, push_acc;
  logic [PW-1:0]                    push_idx, exec_idx, rd_idx;

  twp_sync2 #(.W(NUM_PORTS)) i_req_sync (
    .clk_i, .rst_ni, .d_i(in_req_i), .q_o(req_s));
  twp_sync2 #(.W(NUM_PORTS)) i_ack_sync (
    .clk_i, .rst_ni, .d_i(out_ack_i), .q_o(ack_s));

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chan
    twp_rx_chan #(.WORD_W(WORD_W)) i_rx (
      .clk_i, .rst_ni,
      .req_i   (req_s[p]),
      .word_i  (in_word_i[p]),
      .lock_i  (ctrl_i[2*p+1]),
      .accept_i(accept_w[p]),
      .full_o  (full_w[p]),
      .word_o  (hold_w[p]),
      .ack_o   (in_ack_o[p])
    );
    assign start_w[p] = send_valid_i && (send_port_i == PW'(p));
    twp_tx_chan #(.WORD_W(WORD_W)) i_tx (
      .clk_i, .rst_ni,
      .start_i(start_w[p]),
      .word_i ({ctrl_i[2*p], send_data_i}),
      .ack_i  (ack_s[p]),
      .idle_o (tx_idle_w[p]),
      .req_o  (out_req_o[p]),
      .word_o (out_word_o[p])
    );
  end

  // Route by tag unless a programmed read names the channel; lowest index wins.
  always_comb begin
    want_push = '0;
    want_exec = '0;
    want_rd   = '0;
    push_idx  = '0;
    exec_idx  = '0;
    rd_idx    = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (full_w[p]) begin
        if (rd_req_i && (rd_port_i == PW'(p))) want_rd[p] = 1'b1;
        else if (hold_w[p][DATA_W])           want_exec[p] = 1'b1;
        else                                  want_push[p] = 1'b1;
      end
    end
    for (int p = NUM_PORTS - 1; p >= 0; p--) begin
      if (want_push[p]) push_idx = PW'(p);
      if (want_exec[p]) exec_idx = PW'(p);
      if (want_rd[p])   rd_idx   = PW'(p);
    end
    for (int p = 0; p < NUM_PORTS; p++) begin
      push_acc[p]    = want_push[p] && (push_idx == PW'(p)) && push_ready_i;
      accept_w[p]    = push_acc[p] || want_rd[p] ||
                       (want_exec[p] && (exec_idx == PW'(p)) && exec_ready_i);
    end
  end

  assign push_valid_o = |want_push;
  assign push_data_o  = hold_w[push_idx][DATA_W-1:0];
  assign exec_valid_o = |want_exec;
  assign exec_instr_o = hold_w[exec_idx][DATA_W-1:0];
  assign rd_valid_o   = |want_rd;
  assign rd_word_o    = hold_w[rd_idx];
  assign send_ready_o = tx_idle_w[send_port_i];

  // R8
  push_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(push_acc));
  // R7
  rd_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i && full_w[rd_port_i] |-> rd_valid_o && !push_acc[rd_port_i]);
endmodule

// File: tb/test_tagged_word_port.sv
module test_tagged_word_port;
  localparam int DW = 16;
  localparam int NP = 4;
  localparam int WW = DW + 1;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic [2*NP-1:0]    ctrl_i = '0;
  logic [NP-1:0]      in_req_i = '0;
  logic [NP-1:0][WW-1:0] in_word_i = '0;
  logic [NP-1:0]      in_ack_o;
  logic               push_valid_o, exec_valid_o, rd_valid_o, send_ready_o;
  logic [DW-1:0]      push_data_o, exec_instr_o;
  logic               push_ready_i = 1'b1, exec_ready_i = 1'b1;
  logic               rd_req_i = 1'b0;
  logic [1:0]         rd_port_i = '0;
  logic [WW-1:0]      rd_word_o;
  logic               send_valid_i = 1'b0;
  logic [1:0]         send_port_i = '0;
  logic [DW-1:0]      send_data_i = '0;
  logic [NP-1:0]      out_req_o;
  logic [NP-1:0][WW-1:0] out_word_o;
  logic [NP-1:0]      out_ack_i = '0;

  int errors = 0;
  int checks = 0;
  logic [DW-1:0] push_q[$];
  logic [DW-1:0] exec_q[$];

  always #10 clk_i = ~clk_i;  // 50 MHz

  tagged_word_port #(.DATA_W(DW), .NUM_PORTS(NP)) i_tagged_word_port (.*);

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Scoreboard monitor: compare each accepted word against the queue.
  always @(negedge clk_i) begin
    if (rst_ni && push_valid_o && push_ready_i) begin
      if (push_q.size() == 0) chk(1'b0, "R2/R7 unexpected push", push_data_o, 0);
      else begin
        logic [DW-1:0] e;
        e = push_q.pop_front();
        chk(push_data_o == e, "R2 push data", push_data_o, e);
      end
    end
    if (rst_ni && exec_valid_o && exec_ready_i) begin
      if (exec_q.size() == 0) chk(1'b0, "R3 unexpected exec", exec_instr_o, 0);
      else begin
        logic [DW-1:0] e;
        e = exec_q.pop_front();
        chk(exec_instr_o == e, "R3 exec data", exec_instr_o, e);
      end
    end
  end

  // External sender: word first, then request, four-phase interlock (R1).
  task automatic send_in(input int p, input bit tag, input logic [DW-1:0] d);
    @(negedge clk_i);
    in_word_i[p] = {tag, d};
    @(negedge clk_i);
    in_req_i[p] = 1'b1;
    while (!in_ack_o[p]) @(negedge clk_i);
    in_req_i[p] = 1'b0;
    repeat (4) @(negedge clk_i);
    chk(in_ack_o[p] == 1'b0, "R1 ack released", in_ack_o[p], 0);
  endtask

  task automatic core_send(input int p, input logic [DW-1:0] d);
    @(negedge clk_i);
    send_port_i = 2'(p);
    send_data_i = d;
    while (!send_ready_o) @(negedge clk_i);
    send_valid_i = 1'b1;
    @(negedge clk_i);
    send_valid_i = 1'b0;
  endtask

  // External receiver: delays its acknowledge to observe the request hold.
  task automatic recv_out(input int p, input logic [WW-1:0] exp);
    while (!out_req_o[p]) @(negedge clk_i);
    chk(out_word_o[p] == exp, "R5 output word and tag", out_word_o[p], exp);
    repeat (6) @(negedge clk_i);
    chk(out_req_o[p] && out_word_o[p] == exp, "R6 request and word held",
        out_word_o[p], exp);
    out_ack_i[p] = 1'b1;
    while (out_req_o[p]) @(negedge clk_i);
    out_ack_i[p] = 1'b0;
    repeat (6) @(negedge clk_i);
    chk(out_req_o[p] == 1'b0, "R6 no request before next send", out_req_o[p], 0);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R10 reset state
    chk(in_ack_o == '0 && out_req_o == '0, "R10 reset handshakes",
        {in_ack_o, out_req_o}, 0);
    chk(!push_valid_o && !exec_valid_o && !rd_valid_o, "R10 reset valids",
        {push_valid_o, exec_valid_o, rd_valid_o}, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);

    // R2 data words, R3 instruction words
    push_q.push_back(16'h1234);
    send_in(0, 1'b0, 16'h1234);
    exec_q.push_back(16'h00A5);
    send_in(2, 1'b1, 16'h00A5);
    push_q.push_back(16'hFFFF); send_in(3, 1'b0, 16'hFFFF);
    exec_q.push_back(16'h8001); send_in(3, 1'b1, 16'h8001);
    push_q.push_back(16'h0000); send_in(3, 1'b0, 16'h0000);
    chk(push_q.size() == 0 && exec_q.size() == 0, "R2 R3 all words delivered",
        push_q.size() + exec_q.size(), 0);

    // R9 backpressure then R1 release
    push_ready_i = 1'b0;
    push_q.push_back(16'h55AA);
    fork
      send_in(1, 1'b0, 16'h55AA);
      begin
        repeat (30) @(negedge clk_i);
        chk(in_ack_o[1] == 1'b0, "R9 ack withheld", in_ack_o[1], 0);
        chk(push_valid_o && push_data_o == 16'h55AA, "R9 word held",
            push_data_o, 16'h55AA);
        push_ready_i = 1'b1;
      end
    join

    // R8 priority: channel 0 before channel 2
    push_ready_i = 1'b0;
    push_q.push_back(16'h1000);
    push_q.push_back(16'h2000);
    fork
      send_in(2, 1'b0, 16'h2000);
      send_in(0, 1'b0, 16'h1000);
      begin
        repeat (30) @(negedge clk_i);
        chk(push_data_o == 16'h1000, "R8 lowest channel first", push_data_o, 16'h1000);
        push_ready_i = 1'b1;
      end
    join

    // R4 lock channel 1 (bit 3), output on it still works with tag bit 2
    ctrl_i = 8'b0000_1100;
    push_q.push_back(16'h7777);
    fork
      send_in(1, 1'b0, 16'h7777);
      begin
        repeat (30) @(negedge clk_i);
        chk(in_ack_o[1] == 1'b0 && !push_valid_o, "R4 locked channel ignored",
            {in_ack_o[1], push_valid_o}, 0);
        core_send(1, 16'hBEEF);
        recv_out(1, {1'b1, 16'hBEEF});
        chk(in_ack_o[1] == 1'b0 && !push_valid_o, "R4 still ignored after send",
            {in_ack_o[1], push_valid_o}, 0);
        ctrl_i = 8'b0000_0100;
      end
    join

    // R5 R6 output tags from control bits 0 and 6
    ctrl_i = 8'b0000_0001;
    fork core_send(0, 16'hC0DE); recv_out(0, {1'b1, 16'hC0DE}); join
    fork core_send(3, 16'h0042); recv_out(3, {1'b0, 16'h0042}); join

    // R7 programmed read stalls until channel 2 delivers
    @(negedge clk_i);
    rd_port_i = 2'd2;
    rd_req_i = 1'b1;
    repeat (10) @(negedge clk_i);
    chk(rd_valid_o == 1'b0, "R7 read stalls", rd_valid_o, 0);
    fork
      send_in(2, 1'b0, 16'h0BEE);
      begin
        while (!rd_valid_o) @(negedge clk_i);
        chk(rd_word_o == {1'b0, 16'h0BEE}, "R7 read word", rd_word_o, {1'b0, 16'h0BEE});
        @(negedge clk_i);
        rd_req_i = 1'b0;
      end
    join
    repeat (5) @(negedge clk_i);
    chk(push_q.size() == 0 && exec_q.size() == 0, "R7 nothing left over",
        push_q.size() + exec_q.size(), 0);

    summary();
    $finish;
  end
endmodule